// File: doc/BRIEF.md
# Serial Command and Status Port

This block is the control slave of an audio shock-buffer controller. A host drives three wires: a shift clock, a data line and a load strobe. These pins are asynchronous to the system clock. The block brings them into the system clock domain through synchronizers and acts on their edges there. A write frame has sixteen bits. It carries a data byte and then a command byte. When the load strobe rises, the data byte goes into the control register that the command selects. The control registers are the memory-system control byte, the direction and output-data registers of a five-pin general-purpose port, the mute and compare-width bits, and the option byte.

A read frame has only the command byte. On the load strobe, the block loads the selected status word into a sense shifter. It then presents the word on the sense pin, MSB first, and advances one bit on each falling edge of the shift clock. Three read commands return a status byte. A fourth returns a 16-bit residual count. Reading the first status byte clears its sticky flags.

The block also forms the frame-error flag from an error input and a frame clock. It filters the reset pin, so that only a long low level resets the block.

Top module: `cmd_status_port`

## Requirements
- R1: A frame is shifted in MSB first on rising shift-clock edges. At the load strobe, the last 8 bits are the command and the 8 bits before them are the data. Command 0x80 copies the data to `ms_ctrl`. A frame with any code outside 0x80–0x83, 0x85 and 0x90–0x93 (0x84, for example) changes no register.
- R2: Command 0x81 writes the port direction from data bits 4:0, where 1 means output. The result appears on `port_oe`.
- R3: Command 0x82 writes the port output data from bits 4:0. `port_drv` shows the written value on output bits and 0 on input bits, so the data has no effect on a pin set as an input.
- R4: Command 0x83 sets `mute` from data bit 7 and `cmp12` from data bit 6.
- R5: Command 0x85 stores the option byte. Bits 7:6 go to `mem_cfg` and bits 5:4 go to `ferr_mode`. Bits 3:0 select the compression mode with one bit set: bit 0 gives 4-bit (code 0), bit 1 gives 5-bit (code 1), bit 2 gives 6-bit (code 2) and bit 3 gives full-bit (code 3), shown on `comp_sel`. Any other value of bits 3:0 gives code 2.
- R6: Read 0x90 returns the status byte {frame error, one-shot overflow, buffer overflow, 0, `cmp_busy`, `enc_halt`, decode stopped, 0}, bit 7 first. This read clears all four sticky flags. A flag is set by its event pulse and holds until such a read clears it.
- R7: Read 0x91 returns {`mem_state`[3:0], 0000}.
- R8: Read 0x92 returns the 16 bits of `resid`, MSB first.
- R9: Read 0x93 returns {000, port readback[4:0]}. Each readback bit is the pin level when that bit is an input and the driven data when it is an output.
- R10: The frame-error flag follows `ferr_mode`. Mode 00 sets it on a falling frame-clock edge while the error input is low. Mode 01 sets it on a rising frame-clock edge while the error input is low. Mode 10 sets it while the error input is low. Mode 11 sets it while the error input is high.
- R11: The reset input takes effect only after it has been low for 65 consecutive system clocks. A shorter low pulse leaves all registers unchanged. Release follows on the first clock that samples the input high.
- R12: After reset, every register is 0 and `sense` is 0, except that the option byte is 0x04 (6-bit mode, `comp_sel` = 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_in_n | input | 1 | Raw active-low reset, filtered inside the block |
| sclk | input | 1 | Host shift clock |
| sdata | input | 1 | Host serial data |
| sload | input | 1 | Host load strobe, active on its rising edge |
| sense | output | 1 | Serial status output |
| fr_clk | input | 1 | Frame clock for the error check |
| fr_err | input | 1 | Error input from the disc signal processor |
| ovf_evt | input | 1 | One-cycle pulse that sets the one-shot overflow flag |
| bovf_evt | input | 1 | One-cycle pulse that sets the buffer overflow flag |
| dstop_evt | input | 1 | One-cycle pulse that sets the decode-stopped flag |
| cmp_busy | input | 1 | Level: compare sequence running |
| enc_halt | input | 1 | Level: encoder stopped internally |
| mem_state | input | 4 | Levels reported by read 0x91 |
| resid | input | 16 | Residual data count reported by read 0x92 |
| port_pin | input | 5 | Sensed levels of the port pins |
| port_oe | output | 5 | Port direction, 1 = output |
| port_drv | output | 5 | Port output data, masked by direction |
| ms_ctrl | output | 8 | Memory-system control byte |
| mute | output | 1 | Forced mute |
| cmp12 | output | 1 | 12-bit compare width |
| mem_cfg | output | 2 | Memory configuration select |
| ferr_mode | output | 2 | Frame-error check mode |
| comp_sel | output | 2 | Compression mode code |

## Verification
Each pin edge passes through two synchronizer flops and an edge register. A change on a pin therefore acts on the third rising system clock edge after it is sampled. A register update, a sense-shifter load and a sense bit advance are all due at that edge. The bench holds every serial level for at least three cycles. It samples registers only after the strobe has been low for four more cycles, and reads each sense bit five cycles after the falling shift-clock edge that moved it. Filter checks count whole cycles of low reset: a 64-cycle pulse must leave state unchanged, and a 66-cycle pulse must clear it while the pin is still low.

// File: rtl/cmd_status_pkg.sv
package cmd_status_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = 2 * BYTE_W;
  localparam int RES_W   = 16;

  typedef enum logic [BYTE_W-1:0] {
    CMD_MS   = 8'h80,
    CMD_DIR  = 8'h81,
    CMD_DAT  = 8'h82,
    CMD_MUTE = 8'h83,
    CMD_OPT  = 8'h85,
    CMD_ST1  = 8'h90,
    CMD_ST2  = 8'h91,
    CMD_RES  = 8'h92,
    CMD_PIO  = 8'h93
  } cmd_e;

  typedef enum logic [1:0] {
    CMP_4B   = 2'd0,
    CMP_5B   = 2'd1,
    CMP_6B   = 2'd2,
    CMP_FULL = 2'd3
  } comp_e;

  // Select a mode only when exactly one bit is set; anything else falls back to 6-bit
  function automatic comp_e decode_comp(input logic [3:0] oh);
    case (oh)
      4'b0001: return CMP_4B;
      4'b0010: return CMP_5B;
      4'b1000: return CMP_FULL;
      default: return CMP_6B;
    endcase
  endfunction
endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= {stg_q[STAGES-2:0], din};
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sp_rst_filter.sv
module sp_rst_filter #(
  parameter int LIMIT = 65
) (
  input  logic clk,
  input  logic raw_n,
  output logic rst_n
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_q;

  always_comb begin
    cnt_d = cnt_q;
    if (raw_n)               cnt_d = '0;
    else if (cnt_q != LIM_V) cnt_d = cnt_q + 1'b1;
  end

  // The filter produces the reset, so it has none of its own
  always_ff @(posedge clk) begin
    cnt_q <= cnt_d;
    rst_q <= (cnt_d != LIM_V);
  end

  assign rst_n = rst_q;
endmodule

// File: rtl/sp_ferr_detect.sv
module sp_ferr_detect (
  input  logic [1:0] mode,
  input  logic       fclk_now,
  input  logic       fclk_prev,
  input  logic       err,
  output logic       set_o
);
  always_comb begin
    case (mode)
      2'b00:   set_o = fclk_prev & ~fclk_now & ~err;
      2'b01:   set_o = ~fclk_prev & fclk_now & ~err;
      2'b10:   set_o = ~err;
      default: set_o = err;
    endcase
  end
endmodule

// File: rtl/cmd_status_port.sv
module cmd_status_port
  import cmd_status_pkg::*;
#(
  parameter int PORT_W      = 5,
  parameter int FILT_CYCLES = 65,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_in_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sload,
  output logic              sense,
  input  logic              fr_clk,
  input  logic              fr_err,
  input  logic              ovf_evt,
  input  logic              bovf_evt,
  input  logic              dstop_evt,
  input  logic              cmp_busy,
  input  logic              enc_halt,
  input  logic [3:0]        mem_state,
  input  logic [RES_W-1:0]  resid,
  input  logic [PORT_W-1:0] port_pin,
  output logic [PORT_W-1:0] port_oe,
  output logic [PORT_W-1:0] port_drv,
  output logic [7:0]        ms_ctrl,
  output logic              mute,
  output logic              cmp12,
  output logic [1:0]        mem_cfg,
  output logic [1:0]        ferr_mode,
  output logic [1:0]        comp_sel
);
  localparam int PAD_W = BYTE_W - PORT_W;
  localparam int LOW_W = RES_W - BYTE_W;

  logic                rst_n_int;
  logic [4:0]          pin_s;
  logic                sclk_s, sdata_s, sload_s, fclk_s, ferr_s;
  logic [2:0]          prev_q;
  logic                sclk_rise, sclk_fall, ld_evt, ferr_set;
  logic [FRAME_W-1:0]  shin_q, shin_d;
  logic [RES_W-1:0]    shout_q, shout_d;
  logic [BYTE_W-1:0]   cmd_b, dat_b;
  logic [7:0]          ms_q, ms_d, opt_q, opt_d;
  logic [PORT_W-1:0]   oe_q, oe_d, dat_q, dat_d, pio_rd;
  logic                mute_q, mute_d, cmp12_q, cmp12_d;
  logic                ferr_q, ferr_d, ovf_q, ovf_d, bovf_q, bovf_d, dstop_q, dstop_d;
  logic [BYTE_W-1:0]   st1, st2, st4;

  sp_rst_filter #(.LIMIT(FILT_CYCLES)) u_rst (
    .clk(clk), .raw_n(rst_in_n), .rst_n(rst_n_int)
  );

  sp_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int),
    .din({fr_err, fr_clk, sload, sdata, sclk}), .dout(pin_s)
  );
  assign {ferr_s, fclk_s, sload_s, sdata_s, sclk_s} = pin_s;

  assign sclk_rise = sclk_s & ~prev_q[0];
  assign sclk_fall = ~sclk_s & prev_q[0];
  assign ld_evt    = sload_s & ~prev_q[1];

  sp_ferr_detect u_fd (
    .mode(opt_q[5:4]), .fclk_now(fclk_s), .fclk_prev(prev_q[2]),
    .err(ferr_s), .set_o(ferr_set)
  );

  // Port readback: pin level for inputs, driven data for outputs
  for (genvar g = 0; g < PORT_W; g++) begin : g_pio
    assign pio_rd[g]   = oe_q[g] ? dat_q[g] : port_pin[g];
    assign port_drv[g] = oe_q[g] & dat_q[g];
  end

  assign cmd_b = shin_q[BYTE_W-1:0];
  assign dat_b = shin_q[FRAME_W-1:BYTE_W];
  assign st1   = {ferr_q, ovf_q, bovf_q, 1'b0, cmp_busy, enc_halt, dstop_q, 1'b0};
  assign st2   = {mem_state, 4'b0000};
  assign st4   = {{PAD_W{1'b0}}, pio_rd};

  always_comb begin
    shin_d  = sclk_rise ? {shin_q[FRAME_W-2:0], sdata_s} : shin_q;
    shout_d = sclk_fall ? {shout_q[RES_W-2:0], 1'b0} : shout_q;
    ms_d    = ms_q;
    opt_d   = opt_q;
    oe_d    = oe_q;
    dat_d   = dat_q;
    mute_d  = mute_q;
    cmp12_d = cmp12_q;
    ferr_d  = ferr_q | ferr_set;
    ovf_d   = ovf_q | ovf_evt;
    bovf_d  = bovf_q | bovf_evt;
    dstop_d = dstop_q | dstop_evt;
    if (ld_evt) begin
      case (cmd_b)
        CMD_MS:   ms_d  = dat_b;
        CMD_DIR:  oe_d  = dat_b[PORT_W-1:0];
        CMD_DAT:  dat_d = dat_b[PORT_W-1:0];
        CMD_MUTE: begin
          mute_d  = dat_b[7];
          cmp12_d = dat_b[6];
        end
        CMD_OPT:  opt_d = dat_b;
        CMD_ST1: begin
          shout_d = {st1, {LOW_W{1'b0}}};
          ferr_d  = 1'b0;
          ovf_d   = 1'b0;
          bovf_d  = 1'b0;
          dstop_d = 1'b0;
        end
        CMD_ST2:  shout_d = {st2, {LOW_W{1'b0}}};
        CMD_RES:  shout_d = resid;
        CMD_PIO:  shout_d = {st4, {LOW_W{1'b0}}};
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      prev_q  <= '0;
      shin_q  <= '0;
      shout_q <= '0;
      ms_q    <= '0;
      opt_q   <= 8'h04;
      oe_q    <= '0;
      dat_q   <= '0;
      mute_q  <= 1'b0;
      cmp12_q <= 1'b0;
      ferr_q  <= 1'b0;
      ovf_q   <= 1'b0;
      bovf_q  <= 1'b0;
      dstop_q <= 1'b0;
    end else begin
      prev_q  <= {fclk_s, sload_s, sclk_s};
      shin_q  <= shin_d;
      shout_q <= shout_d;
      ms_q    <= ms_d;
      opt_q   <= opt_d;
      oe_q    <= oe_d;
      dat_q   <= dat_d;
      mute_q  <= mute_d;
      cmp12_q <= cmp12_d;
      ferr_q  <= ferr_d;
      ovf_q   <= ovf_d;
      bovf_q  <= bovf_d;
      dstop_q <= dstop_d;
    end
  end

  assign sense     = shout_q[RES_W-1];
  assign port_oe   = oe_q;
  assign ms_ctrl   = ms_q;
  assign mute      = mute_q;
  assign cmp12     = cmp12_q;
  assign mem_cfg   = opt_q[7:6];
  assign ferr_mode = opt_q[5:4];
  assign comp_sel  = decode_comp(opt_q[3:0]);
endmodule

// File: rtl/cmd_status_port_chk.sv
module cmd_status_port_chk #(
  parameter int PORT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_in_n,
  input logic              ld_evt,
  input logic              sclk_fall,
  input logic [7:0]        cmd_b,
  input logic [7:0]        dat_b,
  input logic [7:0]        ms_ctrl,
  input logic [PORT_W-1:0] port_oe,
  input logic              sense,
  input logic [1:0]        comp_sel,
  input logic [3:0]        opt_lo,
  input logic [3:0]        sticky
);
  // R1
  ms_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_evt |=> $stable(ms_ctrl));

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt && cmd_b == 8'h81) |=> (port_oe == $past(dat_b[PORT_W-1:0])));

  // R5
  comp_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(opt_lo) != 1) |-> (comp_sel == 2'd2));

  // R6
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_evt && cmd_b == 8'h90) |=> (sticky == 4'b0000));

  // R8
  sense_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_evt && !sclk_fall) |=> $stable(sense));

  // R11
  filt_release_chk: assert property (@(posedge clk)
    rst_in_n |=> rst_n);
endmodule

bind cmd_status_port cmd_status_port_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_int), .rst_in_n(rst_in_n), .ld_evt(ld_evt),
  .sclk_fall(sclk_fall), .cmd_b(cmd_b), .dat_b(dat_b), .ms_ctrl(ms_ctrl),
  .port_oe(port_oe), .sense(sense), .comp_sel(comp_sel), .opt_lo(opt_q[3:0]),
  .sticky({ferr_q, ovf_q, bovf_q, dstop_q})
);

// File: tb/cmd_status_port_bench.sv
module cmd_status_port_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_in_n, sclk, sdata, sload, sense, fr_clk, fr_err;
  logic ovf_evt, bovf_evt, dstop_evt, cmp_busy, enc_halt;
  logic [3:0]  mem_state;
  logic [15:0] resid;
  logic [4:0]  port_pin, port_oe, port_drv;
  logic [7:0]  ms_ctrl;
  logic        mute, cmp12;
  logic [1:0]  mem_cfg, ferr_mode, comp_sel;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit done = 0;

  cmd_status_port u_cmd_status_port (
    .clk(clk), .rst_in_n(rst_in_n), .sclk(sclk), .sdata(sdata), .sload(sload),
    .sense(sense), .fr_clk(fr_clk), .fr_err(fr_err), .ovf_evt(ovf_evt),
    .bovf_evt(bovf_evt), .dstop_evt(dstop_evt), .cmp_busy(cmp_busy),
    .enc_halt(enc_halt), .mem_state(mem_state), .resid(resid),
    .port_pin(port_pin), .port_oe(port_oe), .port_drv(port_drv),
    .ms_ctrl(ms_ctrl), .mute(mute), .cmp12(cmp12), .mem_cfg(mem_cfg),
    .ferr_mode(ferr_mode), .comp_sel(comp_sel)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    sdata = b; cyc(3);
    sclk = 1'b1; cyc(3);
    sclk = 1'b0; cyc(3);
  endtask

  task automatic strobe();
    sload = 1'b1; cyc(3);
    sload = 1'b0; cyc(4);
  endtask

  task automatic wr(input logic [7:0] cmd, input logic [7:0] dat);
    for (int i = 7; i >= 0; i--) send_bit(dat[i]);
    for (int i = 7; i >= 0; i--) send_bit(cmd[i]);
    strobe();
  endtask

  task automatic rd(input logic [7:0] cmd, input int nb, output logic [15:0] v);
    v = '0;
    for (int i = 7; i >= 0; i--) send_bit(cmd[i]);
    strobe();
    for (int i = nb - 1; i >= 0; i--) begin
      v[i] = sense;
      sclk = 1'b1; cyc(3);
      sclk = 1'b0; cyc(5);
    end
  endtask

  function automatic logic [1:0] exp_comp(input logic [3:0] n);
    if (n == 4'b0001) return 2'd0;
    if (n == 4'b0010) return 2'd1;
    if (n == 4'b1000) return 2'd3;
    return 2'd2;
  endfunction

  function automatic logic [7:0] exp_pio(input logic [4:0] oe, input logic [4:0] d, input logic [4:0] p);
    return {3'b000, (oe & d) | (~oe & p)};
  endfunction

  task automatic ferr_read(input logic exp, input string tag);
    logic [15:0] v;
    rd(8'h90, 8, v);
    chk(tag, {31'd0, v[7]}, {31'd0, exp});
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) cyc_cnt++;

  initial begin
    wait (cyc_cnt > 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (R1..R12 run) actual=%0d cycles expected=finish", cyc_cnt);
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  d, st, b;
    logic [4:0]  oe, dv, pin;
    void'($urandom(32'd5150));
    rst_in_n = 1'b1; sclk = 0; sdata = 0; sload = 0; fr_clk = 0; fr_err = 1;
    ovf_evt = 0; bovf_evt = 0; dstop_evt = 0; cmp_busy = 0; enc_halt = 0;
    mem_state = 0; resid = 0; port_pin = 0;
    cyc(2);
    rst_in_n = 1'b0; cyc(70);
    rst_in_n = 1'b1; cyc(3);

    // R12 reset state
    chk("R12 ms_ctrl", ms_ctrl, 0);
    chk("R12 port_oe", port_oe, 0);
    chk("R12 port_drv", port_drv, 0);
    chk("R12 mute/cmp12", {mute, cmp12}, 0);
    chk("R12 option", {mem_cfg, ferr_mode, comp_sel}, 6'b0000_10);
    chk("R12 sense", sense, 0);

    // R1 control byte writes and ignored codes
    for (int i = 0; i < 5; i++) begin
      d = 8'($urandom);
      wr(8'h80, d);
      chk("R1 ms_ctrl write", ms_ctrl, d);
    end
    d = ms_ctrl;
    wr(8'h84, 8'hFF);
    chk("R1 code 0x84 ignored", {ms_ctrl, port_oe, mute, cmp12, comp_sel}, {d, 5'd0, 2'b00, 2'd2});
    wr(8'hA5, 8'h3C);
    chk("R1 code 0xA5 ignored", {ms_ctrl, port_oe, mute, cmp12, comp_sel}, {d, 5'd0, 2'b00, 2'd2});

    // R2 R3 R9 port direction, data and readback
    for (int i = 0; i < 6; i++) begin
      oe = 5'($urandom); dv = 5'($urandom); pin = 5'($urandom);
      port_pin = pin;
      wr(8'h81, {3'b111, oe});
      chk("R2 direction", port_oe, oe);
      wr(8'h82, {3'b101, dv});
      chk("R3 masked drive", port_drv, oe & dv);
      rd(8'h93, 8, v);
      chk("R9 readback", v[7:0], exp_pio(oe, dv, pin));
    end
    wr(8'h81, 8'h00);
    wr(8'h82, 8'h1F);
    chk("R3 data on inputs has no effect", port_drv, 0);
    port_pin = 5'b01010;
    rd(8'h93, 8, v);
    chk("R9 all inputs read pins", v[7:0], 8'h0A);

    // R4 mute and compare width
    for (int i = 0; i < 4; i++) begin
      b = {i[1:0], 6'($urandom)};
      wr(8'h83, b);
      chk("R4 mute/cmp12", {mute, cmp12}, b[7:6]);
    end

    // R5 every compression nibble
    for (int n = 0; n < 16; n++) begin
      b = {4'($urandom), n[3:0]};
      wr(8'h85, b);
      chk("R5 option fields", {mem_cfg, ferr_mode, comp_sel}, {b[7:4], exp_comp(n[3:0])});
    end
    wr(8'h85, 8'h04);

    // R7 second status byte
    for (int i = 0; i < 3; i++) begin
      mem_state = 4'($urandom);
      rd(8'h91, 8, v);
      chk("R7 status two", v[7:0], {mem_state, 4'b0000});
    end

    // R8 residual count
    for (int i = 0; i < 4; i++) begin
      resid = (i == 0) ? 16'h8001 : 16'($urandom);
      rd(8'h92, 16, v);
      chk("R8 residual", v, resid);
    end

    // R6 sticky flags set by events, cleared by read
    rd(8'h90, 8, v);
    for (int i = 0; i < 4; i++) begin
      st = 8'($urandom);
      cmp_busy = st[3]; enc_halt = st[2];
      ovf_evt = st[6]; bovf_evt = st[5]; dstop_evt = st[1]; cyc(1);
      ovf_evt = 0; bovf_evt = 0; dstop_evt = 0; cyc(3);
      rd(8'h90, 8, v);
      chk("R6 status one", v[7:0], {1'b0, st[6:5], 1'b0, st[3:1], 1'b0});
      rd(8'h90, 8, v);
      chk("R6 cleared by read", v[7:0], {4'b0000, st[3:2], 2'b00});
    end
    cmp_busy = 0; enc_halt = 0;

    // R10 mode 00: falling frame clock while error low
    fr_err = 1; fr_clk = 0; wr(8'h85, 8'h04); rd(8'h90, 8, v);
    fr_clk = 1; cyc(6); fr_clk = 0; cyc(6);
    ferr_read(1'b0, "R10 mode00 error high");
    fr_err = 0; cyc(4); fr_clk = 1; cyc(6);
    ferr_read(1'b0, "R10 mode00 rising only");
    fr_clk = 0; cyc(6);
    ferr_read(1'b1, "R10 mode00 falling");
    // R10 mode 01: rising frame clock while error low
    fr_err = 1; wr(8'h85, 8'h14); rd(8'h90, 8, v);
    fr_err = 0; cyc(4); fr_clk = 1; cyc(6);
    ferr_read(1'b1, "R10 mode01 rising");
    fr_clk = 0; cyc(6);
    ferr_read(1'b0, "R10 mode01 falling");
    // R10 mode 10: level low
    fr_err = 1; wr(8'h85, 8'h24); rd(8'h90, 8, v);
    ferr_read(1'b0, "R10 mode10 idle");
    fr_err = 0; cyc(6); fr_err = 1; cyc(6);
    ferr_read(1'b1, "R10 mode10 low pulse");
    // R10 mode 11: level high
    fr_err = 0; wr(8'h85, 8'h34); rd(8'h90, 8, v);
    ferr_read(1'b0, "R10 mode11 idle");
    fr_err = 1; cyc(6); fr_err = 0; cyc(6);
    ferr_read(1'b1, "R10 mode11 high pulse");
    wr(8'h85, 8'h04); fr_err = 1;

    // R11 reset filter
    wr(8'h80, 8'h5A);
    rst_in_n = 1'b0; cyc(64); rst_in_n = 1'b1; cyc(3);
    chk("R11 short low ignored", ms_ctrl, 8'h5A);
    rst_in_n = 1'b0; cyc(66);
    chk("R11 long low resets", {ms_ctrl, comp_sel}, {8'h00, 2'd2});
    rst_in_n = 1'b1; cyc(3);

    done = 1;
    summary();
  end
endmodule